// File: doc/BRIEF.md
# A-D Conversion Sequencer with Compare Mode

This block is the digital controller that sits in front of a 10-bit successive-approximation converter core. The core is reached through a simple start/done/data handshake: the controller presents a channel number with a one-cycle start pulse, and later the core returns a done strobe with the 10-bit sample. The controller serves 16 analog inputs. It runs either a single conversion of one chosen channel or a scan over the first 4, 8 or 16 channels. Each channel has its own result register.

In compare mode a conversion does not update any result register. Instead the sample is checked against a reference value latched at start. A flag then records whether the sample was strictly larger. When a run finishes normally, the block emits one completion pulse, steered to either the interrupt line or the DMA request line. A stop command ends a run cleanly after the conversion in flight. Results are read back through a channel-indexed port as a full 10-bit value or as an 8-bit view.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, busy_o, irq_o, dma_req_o, core_start_o and cmp_flag_o are 0, and every result register reads 0.
- R2: With mode_i = 0 (single), a start converts channel chan_i exactly once. The sample is stored in that channel's result register.
- R3: With mode_i = 1, 2 or 3, a start converts channels 0 up to 3, 7 or 15 respectively, in ascending order. Each sample is stored in its own channel's register.
- R4: Only one conversion is outstanding at any time. The next core_start_o pulse (one cycle wide) comes only after the previous done, and that result is already written.
- R5: When cmp_en_i = 1 at start, each conversion sets cmp_flag_o to 1 if the sample is strictly greater than cmp_ref_i (sampled at start) and to 0 otherwise. Result registers are left unchanged.
- R6: A run that completes raises one single-cycle completion pulse, in the cycle after the final done. The pulse appears on irq_o when evt_sel_i = 0 at start and on dma_req_o when evt_sel_i = 1. There is one pulse per single conversion or per whole scan.
- R7: A start_i pulse while busy_o = 1 is ignored: the channel sequence and the run length are unaffected.
- R8: A stop_i pulse during a run lets the current conversion finish and store its result. No further conversion starts, busy_o falls, and no completion pulse is raised.
- R9: With rd_narrow_i = 0, rd_data_o returns the 10-bit result of channel rd_chan_i. With rd_narrow_i = 1, it returns the upper eight result bits in bits 7:0, with bits 9:8 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (taken only when idle) |
| stop_i | input | 1 | Stop the run after the current conversion |
| mode_i | input | 2 | 0 single, 1 scan of 4, 2 scan of 8, 3 scan of 16 |
| chan_i | input | 4 | Channel for single mode |
| cmp_en_i | input | 1 | Compare mode select |
| cmp_ref_i | input | 10 | Compare reference |
| evt_sel_i | input | 1 | Completion routing: 0 interrupt, 1 DMA |
| rd_chan_i | input | 4 | Channel whose result is read |
| rd_narrow_i | input | 1 | 1 selects the 8-bit view |
| rd_data_o | output | 10 | Result read data |
| busy_o | output | 1 | Run in progress |
| cmp_flag_o | output | 1 | Last compare outcome (sample greater than reference) |
| irq_o | output | 1 | Completion interrupt pulse |
| dma_req_o | output | 1 | Completion DMA request pulse |
| core_start_o | output | 1 | Start pulse to converter core |
| core_chan_o | output | 4 | Channel presented to the core |
| core_done_i | input | 1 | Core conversion finished |
| core_data_i | input | 10 | Core conversion sample |

## Verification
A wrong channel counter shows up at core_chan_o at the very next start pulse. The scoreboard compares every presented channel against the expected ascending order, so a skip or repeat is caught within one conversion. A wrong end-of-run or stop state shows up as an extra or missing start and as a miscounted irq_o/dma_req_o pulse within a cycle of the final done. A misdirected write or a compare-mode write shows up later, when every channel is read back through both result views and checked against the bench's model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RUN_SINGLE = 2'd0,
        RUN_SCAN4  = 2'd1,
        RUN_SCAN8  = 2'd2,
        RUN_SCAN16 = 2'd3
    } run_mode_e;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int RES  = 10,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic [1:0]      mode_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            cmp_en_i,
    input  logic [RES-1:0]  cmp_ref_i,
    input  logic            evt_sel_i,
    output logic            core_start_o,
    output logic [CH_W-1:0] core_chan_o,
    input  logic            core_done_i,
    input  logic [RES-1:0]  core_data_i,
    output logic            wr_en_o,
    output logic [CH_W-1:0] wr_chan_o,
    output logic [RES-1:0]  wr_data_o,
    output logic            busy_o,
    output logic            cmp_flag_o,
    output logic            irq_o,
    output logic            dma_req_o
);

    typedef struct packed {
        seq_state_e      state;
        logic [CH_W-1:0] cur;
        logic [CH_W-1:0] last;
        logic            cmp;
        logic            sel;
        logic            stop;
        logic [RES-1:0]  ref_v;
        logic            flag;
        logic            irq;
        logic            dma;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    // Highest channel of a scan, clipped to the channel count.
    function automatic logic [CH_W-1:0] scan_last(input logic [1:0] m);
        int span;
        span = 4 << (int'(m) - 1);
        if (span > NCH) span = NCH;
        return CH_W'(span - 1);
    endfunction

    logic run_end;

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.irq = 1'b0;
        ctrl_d.dma = 1'b0;
        run_end    = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.state = ST_LAUNCH;
                    ctrl_d.cmp   = cmp_en_i;
                    ctrl_d.sel   = evt_sel_i;
                    ctrl_d.ref_v = cmp_ref_i;
                    ctrl_d.stop  = 1'b0;
                    if (run_mode_e'(mode_i) == RUN_SINGLE) begin
                        ctrl_d.cur  = chan_i;
                        ctrl_d.last = chan_i;
                    end else begin
                        ctrl_d.cur  = '0;
                        ctrl_d.last = scan_last(mode_i);
                    end
                end
            end
            ST_LAUNCH: begin
                ctrl_d.state = ST_WAIT;
                if (stop_i) ctrl_d.stop = 1'b1;
            end
            ST_WAIT: begin
                if (stop_i) ctrl_d.stop = 1'b1;
                if (core_done_i) begin
                    if (ctrl_q.cmp) ctrl_d.flag = (core_data_i > ctrl_q.ref_v);
                    if (ctrl_d.stop) begin
                        ctrl_d.state = ST_IDLE;
                    end else if (ctrl_q.cur == ctrl_q.last) begin
                        ctrl_d.state = ST_IDLE;
                        run_end      = 1'b1;
                    end else begin
                        ctrl_d.cur   = ctrl_q.cur + 1'b1;
                        ctrl_d.state = ST_LAUNCH;
                    end
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
        if (run_end) begin
            ctrl_d.irq = ~ctrl_q.sel;
            ctrl_d.dma = ctrl_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign core_start_o = (ctrl_q.state == ST_LAUNCH);
    assign core_chan_o  = ctrl_q.cur;
    assign wr_en_o      = (ctrl_q.state == ST_WAIT) && core_done_i && !ctrl_q.cmp;
    assign wr_chan_o    = ctrl_q.cur;
    assign wr_data_o    = core_data_i;
    assign busy_o       = (ctrl_q.state != ST_IDLE);
    assign cmp_flag_o   = ctrl_q.flag;
    assign irq_o        = ctrl_q.irq;
    assign dma_req_o    = ctrl_q.dma;

    // R4: start to the core is a single-cycle pulse
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_start_o |=> !core_start_o);

    // R6: completion never reaches both destinations
    p_event_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, dma_req_o}));

    // R6: a completion pulse always follows a core done
    p_event_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || dma_req_o) |-> $past(core_done_i));

    // R3: a scan step moves to the next higher channel
    p_scan_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_WAIT && core_done_i && ctrl_d.state == ST_LAUNCH)
        |=> (core_start_o && core_chan_o == $past(core_chan_o) + 1'b1));

    // R7: a start while waiting for the core changes nothing
    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_WAIT && start_i && !core_done_i)
        |=> ($stable(core_chan_o) && busy_o && !core_start_o));

endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
    parameter int NCH    = 16,
    parameter int RES    = 10,
    parameter int NARROW = 8,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [CH_W-1:0] wr_chan_i,
    input  logic [RES-1:0]  wr_data_i,
    input  logic [CH_W-1:0] rd_chan_i,
    input  logic            rd_narrow_i,
    output logic [RES-1:0]  rd_data_o
);

    logic [RES-1:0] res_d [NCH];
    logic [RES-1:0] res_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        always_comb begin
            res_d[g] = res_q[g];
            if (wr_en_i && wr_chan_i == CH_W'(g)) res_d[g] = wr_data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q[g] <= '0;
            else        res_q[g] <= res_d[g];
        end
    end

    logic [RES-1:0] pick;

    always_comb begin
        pick = res_q[rd_chan_i];
        if (rd_narrow_i) rd_data_o = {{(RES-NARROW){1'b0}}, pick[RES-1 -: NARROW]};
        else             rd_data_o = pick;
    end

    // R2: a write lands in the addressed register on the next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (res_q[$past(wr_chan_i)] == $past(wr_data_i)));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int NCH    = 16,
    parameter int RES    = 10,
    parameter int NARROW = 8,
    localparam int CH_W  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            stop_i,
    input  logic [1:0]      mode_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic            cmp_en_i,
    input  logic [RES-1:0]  cmp_ref_i,
    input  logic            evt_sel_i,
    input  logic [CH_W-1:0] rd_chan_i,
    input  logic            rd_narrow_i,
    output logic [RES-1:0]  rd_data_o,
    output logic            busy_o,
    output logic            cmp_flag_o,
    output logic            irq_o,
    output logic            dma_req_o,
    output logic            core_start_o,
    output logic [CH_W-1:0] core_chan_o,
    input  logic            core_done_i,
    input  logic [RES-1:0]  core_data_i
);

    logic            wr_en;
    logic [CH_W-1:0] wr_chan;
    logic [RES-1:0]  wr_data;

    adc_seq_ctrl #(.NCH(NCH), .RES(RES)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .mode_i       (mode_i),
        .chan_i       (chan_i),
        .cmp_en_i     (cmp_en_i),
        .cmp_ref_i    (cmp_ref_i),
        .evt_sel_i    (evt_sel_i),
        .core_start_o (core_start_o),
        .core_chan_o  (core_chan_o),
        .core_done_i  (core_done_i),
        .core_data_i  (core_data_i),
        .wr_en_o      (wr_en),
        .wr_chan_o    (wr_chan),
        .wr_data_o    (wr_data),
        .busy_o       (busy_o),
        .cmp_flag_o   (cmp_flag_o),
        .irq_o        (irq_o),
        .dma_req_o    (dma_req_o)
    );

    adc_seq_store #(.NCH(NCH), .RES(RES), .NARROW(NARROW)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_chan_i   (wr_chan),
        .wr_data_i   (wr_data),
        .rd_chan_i   (rd_chan_i),
        .rd_narrow_i (rd_narrow_i),
        .rd_data_o   (rd_data_o)
    );

endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0;
    logic [1:0] mode_i = '0;
    logic [3:0] chan_i = '0;
    logic       cmp_en_i = 1'b0;
    logic [9:0] cmp_ref_i = '0;
    logic       evt_sel_i = 1'b0;
    logic [3:0] rd_chan_i = '0;
    logic       rd_narrow_i = 1'b0;
    logic [9:0] rd_data_o;
    logic       busy_o, cmp_flag_o, irq_o, dma_req_o, core_start_o;
    logic [3:0] core_chan_o;
    logic       core_done_i = 1'b0;
    logic [9:0] core_data_i = '0;

    always #10 clk = ~clk;

    adc_seq_top i_adc_seq_top (.*);

    int n_chk = 0, n_fail = 0;
    int cnum = 0, start_cnt = 0, irq_cnt = 0, dma_cnt = 0;
    int exp_ch[$];
    logic [9:0] res_model [16];
    bit   flag_model = 1'b0;
    bit   tb_cmp = 1'b0;
    logic [9:0] tb_ref = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] sample_of(input int ch, input int n);
        return 10'((ch * 61 + n * 29 + 7) % 1024);
    endfunction

    // Converter core model and scoreboard monitor
    initial begin
        @(negedge clk);
        forever begin
            if (core_start_o) begin
                int ch, lat;
                bit overlap;
                logic [9:0] d;
                ch = int'(core_chan_o);
                start_cnt++;
                if (exp_ch.size() == 0) begin
                    chk("R7/R8 unexpected start", 32'(ch), 32'hFFFF);
                end else begin
                    chk("R2/R3 channel order", 32'(ch), 32'(exp_ch.pop_front()));
                end
                lat = 1 + (cnum % 3);
                d = sample_of(ch, cnum);
                cnum++;
                overlap = 1'b0;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (core_start_o) overlap = 1'b1;
                end
                core_done_i = 1'b1;
                core_data_i = d;
                if (tb_cmp) flag_model = (d > tb_ref);
                else        res_model[ch] = d;
                @(negedge clk);
                core_done_i = 1'b0;
                chk("R4 single outstanding", 32'(overlap), 32'd0);
            end else begin
                @(negedge clk);
            end
        end
    end

    always @(negedge clk) begin
        if (irq_o) irq_cnt++;
        if (dma_req_o) dma_cnt++;
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic push_run(input logic [1:0] m, input logic [3:0] ch);
        if (m == 2'd0) exp_ch.push_back(int'(ch));
        else for (int i = 0; i < (4 << (m - 1)); i++) exp_ch.push_back(i);
    endtask

    task automatic kick(input logic [1:0] m, input logic [3:0] ch, input bit cmp,
                        input bit sel, input logic [9:0] rv);
        tb_cmp = cmp;
        tb_ref = rv;
        @(negedge clk);
        mode_i = m; chan_i = ch; cmp_en_i = cmp; cmp_ref_i = rv; evt_sel_i = sel;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run(input logic [1:0] m, input logic [3:0] ch, input bit cmp,
                       input bit sel, input logic [9:0] rv);
        push_run(m, ch);
        kick(m, ch, cmp, sel, rv);
        wait_idle();
    endtask

    task automatic readback(input string req);
        for (int c = 0; c < 16; c++) begin
            rd_chan_i = 4'(c);
            rd_narrow_i = 1'b0;
            #1;
            chk({req, " R9 wide view"}, 32'(rd_data_o), 32'(res_model[c]));
            rd_narrow_i = 1'b1;
            #1;
            chk({req, " R9 narrow view"}, 32'(rd_data_o), {24'd0, res_model[c][9:2]});
        end
        rd_narrow_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int i0, d0, s0;
        logic [9:0] nxt;
        for (int c = 0; c < 16; c++) res_model[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 irq/dma", 32'({irq_o, dma_req_o}), 0);
        chk("R1 core_start", 32'(core_start_o), 0);
        chk("R1 cmp_flag", 32'(cmp_flag_o), 0);
        rd_chan_i = 4'd3;
        #1 chk("R1 result zero", 32'(rd_data_o), 0);

        // R2 + R6: single conversion, interrupt routing
        i0 = irq_cnt; d0 = dma_cnt;
        run(2'd0, 4'd5, 1'b0, 1'b0, '0);
        chk("R6 irq once single", 32'(irq_cnt - i0), 1);
        chk("R6 no dma single", 32'(dma_cnt - d0), 0);
        readback("R2");

        // R3 + R6: scan of 4 routed to DMA
        i0 = irq_cnt; d0 = dma_cnt;
        run(2'd1, 4'd0, 1'b0, 1'b1, '0);
        chk("R6 dma once scan4", 32'(dma_cnt - d0), 1);
        chk("R6 no irq scan4", 32'(irq_cnt - i0), 0);
        readback("R3 scan4");

        // R3 + R7: scan of 16 with a stray start while busy
        i0 = irq_cnt;
        push_run(2'd3, 4'd0);
        kick(2'd3, 4'd0, 1'b0, 1'b0, '0);
        while (start_cnt < 18) @(negedge clk);
        mode_i = 2'd0; chan_i = 4'd9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk("R7 queue drained", 32'(exp_ch.size()), 0);
        chk("R6 irq once scan16", 32'(irq_cnt - i0), 1);
        readback("R3/R7 scan16");

        // R3: scan of 8
        run(2'd2, 4'd0, 1'b0, 1'b0, '0);
        readback("R3 scan8");

        // R8: stop during third conversion of a scan of 8
        i0 = irq_cnt; d0 = dma_cnt; s0 = start_cnt;
        for (int i = 0; i < 3; i++) exp_ch.push_back(i);
        kick(2'd2, 4'd0, 1'b0, 1'b0, '0);
        while (start_cnt < s0 + 3) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R8 starts after stop", 32'(start_cnt - s0), 3);
        chk("R8 busy low", 32'(busy_o), 0);
        chk("R8 no event", 32'((irq_cnt - i0) + (dma_cnt - d0)), 0);
        readback("R8");

        // R5: compare mode, sample greater than reference
        nxt = sample_of(5, cnum);
        run(2'd0, 4'd5, 1'b1, 1'b0, nxt - 10'd1);
        chk("R5 flag greater", 32'(cmp_flag_o), 32'(flag_model));
        chk("R5 flag expect 1", 32'(cmp_flag_o), 1);
        // R5: equal is not greater
        nxt = sample_of(5, cnum);
        run(2'd0, 4'd5, 1'b1, 1'b1, nxt);
        chk("R5 flag equal", 32'(cmp_flag_o), 0);
        readback("R5 result untouched");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule